// File: doc/BRIEF.md
# Receive Packet Buffer with Head Status

This block sits between a receive MAC and the host side of a network controller. The MAC pushes packet bytes one per cycle and marks the final byte together with a 4-bit error class. The block keeps the bytes in a circular byte store and records one descriptor (length and class) per finished packet. The host reads bytes of the oldest packet in order and then drops whatever is left of it with a discard request.

A 16-bit head status word always describes the oldest packet. When no finished packet is held, the word describes the packet still arriving, or it reports an empty buffer. Two independent limits block reception. The first is a full byte store. The second is a full descriptor ring. Each limit clears by itself once the host frees room. Reading past the bytes held for the head packet sets a sticky underrun that also raises an adapter-failure output. Only a receive reset or the global reset clears it.

Top module: `rx_pkt_buffer`

## Requirements
- R1: After reset, head_status_o is 16'h8000 and pkt_count_o is 0. receiving_o, byte_ovr_o, pkt_ovr_o, underrun_o, adapter_fail_o, rx_done_o and host_data_vld_o are all low.
- R2: The head status word has three fields. Bit 15 is 1 when the head packet is still arriving or the buffer is empty. Bits 14:11 hold the error class. Bits 10:0 hold the byte count. For a finished head packet the word is {1'b0, class, length}.
- R3: Each accepted host_rd_i returns the next byte of the head packet on host_data_o, with host_data_vld_o high, in the cycle after the request. Bytes come out in arrival order.
- R4: The class on mac_cls_i with the final byte is stored unchanged when the block itself saw no truncation. Examples are 1101 (CRC), 1011 (runt), 1100 (alignment) and 0010 (dribble).
- R5: A packet longer than MAX_LEN keeps only its first MAX_LEN bytes. It is reported with class 1001 and length MAX_LEN.
- R6: byte_ovr_o is high while the byte store is full. A packet that meets a full store mid-way keeps the bytes already stored and is reported with class 1000. A packet that starts while byte_ovr_o is high is dropped whole. The flag falls after one byte is read.
- R7: pkt_ovr_o is high while PKT_MAX finished packets are held. A packet that starts then is dropped whole and never reaches the head. The flag falls after one discard.
- R8: A read when every byte of the head packet received so far has been read returns no data. It sets underrun_o and adapter_fail_o, which stay high until rx_reset_i or rst_n.
- R9: host_discard_i drops the rest of a finished head packet and makes the next packet the head. It has no effect when no finished packet is held. It takes priority over a read in the same cycle, which is then ignored.
- R10: receiving_o is high from the cycle after an accepted non-final byte until the cycle after the final byte.
- R11: rx_done_o pulses for one cycle, in the cycle after the final byte of a stored packet. It does not pulse for a dropped packet.
- R12: rx_reset_i empties the buffer and clears underrun. The remainder of a packet in flight is dropped.
- R13: While the oldest packet is still arriving, the status is {1'b1, 4'b0000, bytes so far}. The host may read up to that many bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| rx_reset_i | input | 1 | Synchronous receive reset |
| mac_valid_i | input | 1 | MAC byte valid |
| mac_data_i | input | 8 | MAC byte |
| mac_last_i | input | 1 | Final byte of packet |
| mac_cls_i | input | 4 | Error class sampled with the final byte |
| host_rd_i | input | 1 | Read one byte of the head packet |
| host_discard_i | input | 1 | Drop the rest of the head packet |
| host_data_o | output | 8 | Byte read |
| host_data_vld_o | output | 1 | host_data_o is valid |
| head_status_o | output | 16 | Head packet status word |
| pkt_count_o | output | CNT_W | Finished packets held |
| receiving_o | output | 1 | Packet being written |
| byte_ovr_o | output | 1 | Byte store full |
| pkt_ovr_o | output | 1 | Packet limit reached |
| underrun_o | output | 1 | Sticky read-past-data flag |
| adapter_fail_o | output | 1 | Failure indication raised by underrun |
| rx_done_o | output | 1 | Packet committed pulse |

## Verification
The bench builds the block with DEPTH=16, PKT_MAX=4 and MAX_LEN=10. Two packets fill the byte store and four reach the packet limit, so both blocking conditions and their self-clearing are reached within a few dozen cycles. A sweep over every length from 1 to MAX_LEN+2 takes the pointers around the store many times. It covers the oversize boundary on both sides, and each expected byte and status word is computed from the packet index.

// File: rtl/rxpb_pkg.sv
package rxpb_pkg;
  localparam int unsigned LEN_W = 11;
  localparam int unsigned CLS_W = 4;
  localparam logic [CLS_W-1:0] CLS_NONE     = 4'b0000;
  localparam logic [CLS_W-1:0] CLS_OVERRUN  = 4'b1000;
  localparam logic [CLS_W-1:0] CLS_OVERSIZE = 4'b1001;

  typedef enum logic [1:0] {WS_IDLE, WS_RECV, WS_DROP} wr_state_e;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic [LEN_W-1:0] len;
  } pkt_desc_t;

  function automatic logic [15:0] pack_status(input logic pending,
                                              input logic [CLS_W-1:0] cls,
                                              input logic [LEN_W-1:0] len);
    return {pending, cls, len};
  endfunction
endpackage

// File: rtl/rxpb_byte_store.sv
module rxpb_byte_store
  import rxpb_pkg::*;
#(
  parameter int unsigned DEPTH = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             we_i,
  input  logic [7:0]       wdata_i,
  input  logic             re_i,
  input  logic             skip_i,
  input  logic [LEN_W-1:0] skip_len_i,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  output logic             full_o
);
  localparam int unsigned PTR_W  = $clog2(DEPTH);
  localparam int unsigned USED_W = PTR_W + 1;

  logic [7:0]        mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [USED_W-1:0] used_q, used_n, dec;
  logic [7:0]        rdata_q;
  logic              rvalid_q, rvalid_n;

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    used_n   = used_q;
    rvalid_n = 1'b0;
    dec      = '0;
    if (clear_i) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      used_n   = '0;
    end else begin
      if (we_i) wr_ptr_n = wr_ptr_q + 1'b1;
      if (re_i) begin
        rd_ptr_n = rd_ptr_q + 1'b1;
        dec      = USED_W'(1);
        rvalid_n = 1'b1;
      end else if (skip_i) begin
        rd_ptr_n = rd_ptr_q + PTR_W'(skip_len_i);
        dec      = USED_W'(skip_len_i);
      end
      used_n = used_q + USED_W'(we_i) - dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      used_q   <= '0;
      rvalid_q <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      used_q   <= used_n;
      rvalid_q <= rvalid_n;
    end
  end

  always_ff @(posedge clk) begin
    if (we_i && !clear_i) mem_q[wr_ptr_q] <= wdata_i;
    if (re_i && !clear_i) rdata_q <= mem_q[rd_ptr_q];
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign full_o   = (used_q == USED_W'(DEPTH));

  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= USED_W'(DEPTH)); // R6
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> !full_o); // R6
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    re_i |-> (used_q != '0)); // R8
endmodule

// File: rtl/rxpb_desc_ring.sv
module rxpb_desc_ring
  import rxpb_pkg::*;
#(
  parameter int unsigned PKT_MAX = 8,
  localparam int unsigned CNT_W = $clog2(PKT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             push_i,
  input  pkt_desc_t        push_desc_i,
  input  logic             pop_i,
  output pkt_desc_t        head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  localparam int unsigned IDX_W = (PKT_MAX > 1) ? $clog2(PKT_MAX) : 1;

  pkt_desc_t         ent_q [PKT_MAX];
  logic [IDX_W-1:0]  wr_idx_q, wr_idx_n, rd_idx_q, rd_idx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(PKT_MAX - 1)) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    wr_idx_n = wr_idx_q;
    rd_idx_n = rd_idx_q;
    cnt_n    = cnt_q;
    if (clear_i) begin
      wr_idx_n = '0;
      rd_idx_n = '0;
      cnt_n    = '0;
    end else begin
      if (push_i) wr_idx_n = step(wr_idx_q);
      if (pop_i)  rd_idx_n = step(rd_idx_q);
      cnt_n = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_idx_q <= wr_idx_n;
      rd_idx_q <= rd_idx_n;
      cnt_q    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !clear_i) ent_q[wr_idx_q] <= push_desc_i;
  end

  assign head_o  = ent_q[rd_idx_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(PKT_MAX));

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PKT_MAX)); // R7
  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R7
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_q != '0)); // R9
endmodule

// File: rtl/rxpb_wr_ctrl.sv
module rxpb_wr_ctrl
  import rxpb_pkg::*;
#(
  parameter int unsigned MAX_LEN = 1514
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_reset_i,
  input  logic             mac_valid_i,
  input  logic             mac_last_i,
  input  logic [CLS_W-1:0] mac_cls_i,
  input  logic             store_full_i,
  input  logic             ring_full_i,
  output logic             store_we_o,
  output logic             commit_o,
  output pkt_desc_t        commit_desc_o,
  output logic [LEN_W-1:0] arrive_len_o,
  output logic             receiving_o,
  output logic             done_o
);
  wr_state_e        state_q, state_n;
  logic [LEN_W-1:0] len_q, len_n, len_plus;
  logic             cut_q, cut_n;
  logic [CLS_W-1:0] cutcls_q, cutcls_n, fresh_cls, end_cls;
  logic             room, keep, blocked, take, done_q;

  always_comb begin
    state_n   = state_q;
    len_n     = len_q;
    cut_n     = cut_q;
    cutcls_n  = cutcls_q;
    store_we_o    = 1'b0;
    commit_o      = 1'b0;
    commit_desc_o = '{cls: CLS_NONE, len: '0};
    room      = !store_full_i && (len_q < LEN_W'(MAX_LEN));
    keep      = !cut_q && room;
    len_plus  = len_q + LEN_W'(keep);
    fresh_cls = store_full_i ? CLS_OVERRUN : CLS_OVERSIZE;
    end_cls   = cut_q ? cutcls_q : (room ? mac_cls_i : fresh_cls);
    blocked   = store_full_i || ring_full_i;
    take      = mac_valid_i &&
                ((state_q == WS_RECV) || ((state_q == WS_IDLE) && !blocked));
    if (rx_reset_i) begin
      len_n    = '0;
      cut_n    = 1'b0;
      cutcls_n = CLS_NONE;
      state_n  = (((state_q != WS_IDLE) || mac_valid_i) && !(mac_valid_i && mac_last_i))
                 ? WS_DROP : WS_IDLE;
    end else if (take) begin
      store_we_o = keep;
      if (mac_last_i) begin
        commit_o      = 1'b1;
        commit_desc_o = '{cls: end_cls, len: len_plus};
        state_n  = WS_IDLE;
        len_n    = '0;
        cut_n    = 1'b0;
        cutcls_n = CLS_NONE;
      end else begin
        state_n = WS_RECV;
        len_n   = len_plus;
        if (!cut_q && !room) begin
          cut_n    = 1'b1;
          cutcls_n = fresh_cls;
        end
      end
    end else if (mac_valid_i) begin
      if (state_q == WS_DROP) begin
        if (mac_last_i) state_n = WS_IDLE;
      end else if (!mac_last_i) begin
        state_n = WS_DROP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WS_IDLE;
      len_q    <= '0;
      cut_q    <= 1'b0;
      cutcls_q <= CLS_NONE;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      len_q    <= len_n;
      cut_q    <= cut_n;
      cutcls_q <= cutcls_n;
      done_q   <= commit_o;
    end
  end

  assign arrive_len_o = len_q;
  assign receiving_o  = (state_q == WS_RECV);
  assign done_o       = done_q;

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(mac_valid_i && mac_last_i)); // R11
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(MAX_LEN)); // R5
  AST_NO_COMMIT_RING_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !ring_full_i); // R7
endmodule

// File: rtl/rxpb_rd_ctrl.sv
module rxpb_rd_ctrl
  import rxpb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_reset_i,
  input  logic             rd_i,
  input  logic             discard_i,
  input  logic             have_pkt_i,
  input  logic [LEN_W-1:0] head_len_i,
  output logic             re_o,
  output logic             skip_o,
  output logic [LEN_W-1:0] skip_len_o,
  output logic             pop_o,
  output logic             underrun_o
);
  logic [LEN_W-1:0] off_q, off_n;
  logic             und_q, und_n;

  always_comb begin
    off_n      = off_q;
    und_n      = und_q;
    re_o       = 1'b0;
    skip_o     = 1'b0;
    pop_o      = 1'b0;
    skip_len_o = head_len_i - off_q;
    if (rx_reset_i) begin
      off_n = '0;
      und_n = 1'b0;
    end else if (discard_i) begin
      if (have_pkt_i) begin
        skip_o = 1'b1;
        pop_o  = 1'b1;
        off_n  = '0;
      end
    end else if (rd_i) begin
      if (off_q < head_len_i) begin
        re_o  = 1'b1;
        off_n = off_q + 1'b1;
      end else begin
        und_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      und_q <= 1'b0;
    end else begin
      off_q <= off_n;
      und_q <= und_n;
    end
  end

  assign underrun_o = und_q;

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(und_q) |-> $past(rx_reset_i)); // R8
  AST_OFFSET_WITHIN_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= head_len_i); // R13
endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer
  import rxpb_pkg::*;
#(
  parameter int unsigned DEPTH   = 2048,
  parameter int unsigned PKT_MAX = 8,
  parameter int unsigned MAX_LEN = 1514,
  localparam int unsigned CNT_W  = $clog2(PKT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_reset_i,
  input  logic             mac_valid_i,
  input  logic [7:0]       mac_data_i,
  input  logic             mac_last_i,
  input  logic [3:0]       mac_cls_i,
  input  logic             host_rd_i,
  input  logic             host_discard_i,
  output logic [7:0]       host_data_o,
  output logic             host_data_vld_o,
  output logic [15:0]      head_status_o,
  output logic [CNT_W-1:0] pkt_count_o,
  output logic             receiving_o,
  output logic             byte_ovr_o,
  output logic             pkt_ovr_o,
  output logic             underrun_o,
  output logic             adapter_fail_o,
  output logic             rx_done_o
);
  logic             store_full, ring_full, we, commit, re, skip, pop, have_pkt, und;
  logic [LEN_W-1:0] skip_len, arrive_len, head_len;
  pkt_desc_t        commit_desc, head_desc;

  rxpb_wr_ctrl #(.MAX_LEN(MAX_LEN)) u_wr (
    .clk(clk), .rst_n(rst_n), .rx_reset_i(rx_reset_i),
    .mac_valid_i(mac_valid_i), .mac_last_i(mac_last_i), .mac_cls_i(mac_cls_i),
    .store_full_i(store_full), .ring_full_i(ring_full),
    .store_we_o(we), .commit_o(commit), .commit_desc_o(commit_desc),
    .arrive_len_o(arrive_len), .receiving_o(receiving_o), .done_o(rx_done_o)
  );

  rxpb_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clear_i(rx_reset_i),
    .we_i(we), .wdata_i(mac_data_i),
    .re_i(re), .skip_i(skip), .skip_len_i(skip_len),
    .rdata_o(host_data_o), .rvalid_o(host_data_vld_o), .full_o(store_full)
  );

  rxpb_desc_ring #(.PKT_MAX(PKT_MAX)) u_ring (
    .clk(clk), .rst_n(rst_n), .clear_i(rx_reset_i),
    .push_i(commit), .push_desc_i(commit_desc), .pop_i(pop),
    .head_o(head_desc), .count_o(pkt_count_o), .full_o(ring_full)
  );

  rxpb_rd_ctrl u_rd (
    .clk(clk), .rst_n(rst_n), .rx_reset_i(rx_reset_i),
    .rd_i(host_rd_i), .discard_i(host_discard_i),
    .have_pkt_i(have_pkt), .head_len_i(head_len),
    .re_o(re), .skip_o(skip), .skip_len_o(skip_len), .pop_o(pop),
    .underrun_o(und)
  );

  assign have_pkt       = (pkt_count_o != '0);
  assign head_len       = have_pkt ? head_desc.len : arrive_len;
  assign head_status_o  = have_pkt ? pack_status(1'b0, head_desc.cls, head_desc.len)
                                   : pack_status(1'b1, CLS_NONE, arrive_len);
  assign byte_ovr_o     = store_full;
  assign pkt_ovr_o      = ring_full;
  assign underrun_o     = und;
  assign adapter_fail_o = und;

  AST_DATA_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_vld_o |-> $past(host_rd_i && !host_discard_i && !rx_reset_i)); // R3
  AST_DONE_COUNTS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_o && !$past(host_discard_i)) |-> (pkt_count_o != '0)); // R11
endmodule

// File: tb/test_rx_pkt_buffer.sv
module test_rx_pkt_buffer;
  localparam int DEPTH   = 16;
  localparam int PKT_MAX = 4;
  localparam int MAX_LEN = 10;
  localparam int CNT_W   = $clog2(PKT_MAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0, rx_reset = 1'b0;
  logic mac_valid = 1'b0, mac_last = 1'b0, host_rd = 1'b0, host_discard = 1'b0;
  logic [7:0] mac_data = '0;
  logic [3:0] mac_cls = '0;
  logic [7:0] host_data;
  logic host_vld, receiving, byte_ovr, pkt_ovr, underrun, afail, rx_done;
  logic [15:0] status;
  logic [CNT_W-1:0] pcount;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rx_pkt_buffer #(.DEPTH(DEPTH), .PKT_MAX(PKT_MAX), .MAX_LEN(MAX_LEN)) i_rx_pkt_buffer (
    .clk(clk), .rst_n(rst_n), .rx_reset_i(rx_reset),
    .mac_valid_i(mac_valid), .mac_data_i(mac_data), .mac_last_i(mac_last), .mac_cls_i(mac_cls),
    .host_rd_i(host_rd), .host_discard_i(host_discard),
    .host_data_o(host_data), .host_data_vld_o(host_vld), .head_status_o(status),
    .pkt_count_o(pcount), .receiving_o(receiving), .byte_ovr_o(byte_ovr), .pkt_ovr_o(pkt_ovr),
    .underrun_o(underrun), .adapter_fail_o(afail), .rx_done_o(rx_done)
  );

  task automatic check(input string tag, input int unsigned act, input int unsigned exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 7 + i * 3 + 1) & 255);
  endfunction

  function automatic logic [15:0] st(input logic pend, input logic [3:0] cls, input int len);
    return {pend, cls, 11'(len)};
  endfunction

  function automatic logic [3:0] cls_for(input int k);
    case (k % 5)
      0: return 4'b0000;
      1: return 4'b1101;
      2: return 4'b0010;
      3: return 4'b1011;
      default: return 4'b1100;
    endcase
  endfunction

  task automatic put_byte(input logic [7:0] d, input logic last, input logic [3:0] cls);
    @(negedge clk);
    mac_valid = 1'b1; mac_data = d; mac_last = last; mac_cls = cls;
  endtask

  task automatic idle_wr();
    @(negedge clk);
    mac_valid = 1'b0; mac_last = 1'b0;
  endtask

  task automatic send_pkt(input int len, input int seed, input logic [3:0] cls);
    for (int i = 0; i < len; i++) put_byte(pat(seed, i), (i == len - 1), cls);
    idle_wr();
  endtask

  task automatic rd_byte(input logic [7:0] exp, input string tag);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    check(tag, host_vld, 1, "read valid");
    check(tag, host_data, exp, "read data");
  endtask

  task automatic discard();
    @(negedge clk); host_discard = 1'b1;
    @(negedge clk); host_discard = 1'b0;
  endtask

  task automatic pulse_rx_reset();
    @(negedge clk); rx_reset = 1'b1; mac_valid = 1'b0; mac_last = 1'b0;
    @(negedge clk); rx_reset = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", status, 16'h8000, "status");
    check("R1", pcount, 0, "count");
    check("R1", {receiving, byte_ovr, pkt_ovr, underrun, afail, rx_done, host_vld}, 0, "flags");

    // Sweep over lengths: R2 R3 R4 R5 R11 R9
    for (int len = 1; len <= MAX_LEN + 2; len++) begin
      automatic logic [3:0] c = cls_for(len);
      automatic int elen = (len > MAX_LEN) ? MAX_LEN : len;
      automatic logic [3:0] ecls = (len > MAX_LEN) ? 4'b1001 : c;
      send_pkt(len, len, c);
      check("R11", rx_done, 1, "done pulse");
      check("R2", pcount, 1, "count after packet");
      check((len > MAX_LEN) ? "R5" : "R4", status, st(1'b0, ecls, elen), "status");
      for (int i = 0; i < elen; i++) rd_byte(pat(len, i), "R3");
      discard();
      check("R9", pcount, 0, "count after discard");
      check("R9", status, 16'h8000, "status after discard");
    end

    // R10 / R13 early reading of an arriving packet
    put_byte(pat(40, 0), 1'b0, 4'b0);
    put_byte(pat(40, 1), 1'b0, 4'b0);
    check("R10", receiving, 1, "receiving mid packet");
    put_byte(pat(40, 2), 1'b0, 4'b0);
    idle_wr();
    check("R13", status, st(1'b1, 4'b0, 3), "arriving status");
    discard();
    check("R9", status, st(1'b1, 4'b0, 3), "discard ignored status");
    check("R9", pcount, 0, "discard ignored count");
    rd_byte(pat(40, 0), "R13");
    rd_byte(pat(40, 1), "R13");
    put_byte(pat(40, 3), 1'b0, 4'b0);
    put_byte(pat(40, 4), 1'b1, 4'b1101);
    idle_wr();
    check("R10", receiving, 0, "receiving after last");
    check("R11", rx_done, 1, "done early packet");
    check("R2", status, 16'h6805, "finished status");
    for (int i = 2; i < 5; i++) rd_byte(pat(40, i), "R13");

    // R8 underrun
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    check("R8", host_vld, 0, "no data past end");
    check("R8", underrun, 1, "underrun set");
    check("R8", afail, 1, "adapter fail set");
    discard();
    send_pkt(2, 50, 4'b0);
    check("R8", underrun, 1, "underrun sticky");
    pulse_rx_reset();
    check("R12", underrun, 0, "underrun cleared");
    check("R12", pcount, 0, "reset empties");
    check("R12", status, 16'h8000, "reset status");

    // R7 packet limit
    for (int p = 0; p < PKT_MAX; p++) begin
      send_pkt(2, 60 + p, 4'b0);
      check("R7", pcount, p + 1, "count while filling");
    end
    check("R7", pkt_ovr, 1, "packet limit flag");
    send_pkt(2, 64, 4'b0);
    check("R7", rx_done, 0, "no done for dropped");
    check("R7", pcount, PKT_MAX, "count unchanged");
    @(negedge clk); host_rd = 1'b1; host_discard = 1'b1;
    @(negedge clk); host_rd = 1'b0; host_discard = 1'b0;
    check("R9", host_vld, 0, "read ignored under discard");
    check("R7", pkt_ovr, 0, "packet limit cleared");
    check("R9", pcount, PKT_MAX - 1, "count after discard");
    check("R9", status, st(1'b0, 4'b0, 2), "next head status");
    rd_byte(pat(61, 0), "R9");
    for (int p = 0; p < PKT_MAX - 1; p++) discard();
    check("R7", pcount, 0, "dropped packet never held");
    check("R7", status, 16'h8000, "empty after drain");

    // R6 byte store overrun
    send_pkt(10, 70, 4'b0);
    send_pkt(9, 71, 4'b1101);
    check("R6", rx_done, 1, "truncated packet committed");
    check("R6", byte_ovr, 1, "byte full flag");
    check("R6", pcount, 2, "two packets");
    send_pkt(2, 72, 4'b0);
    check("R6", rx_done, 0, "no done while full");
    check("R6", pcount, 2, "packet dropped while full");
    rd_byte(pat(70, 0), "R6");
    check("R6", byte_ovr, 0, "flag clears after read");
    discard();
    check("R6", status, 16'h4006, "truncated status");
    for (int i = 0; i < 6; i++) rd_byte(pat(71, i), "R6");
    discard();

    // R12 receive reset during a packet
    put_byte(pat(80, 0), 1'b0, 4'b0);
    put_byte(pat(80, 1), 1'b0, 4'b0);
    pulse_rx_reset();
    put_byte(pat(80, 2), 1'b1, 4'b0);
    idle_wr();
    check("R12", rx_done, 0, "tail dropped");
    check("R12", pcount, 0, "tail not held");
    check("R12", status, 16'h8000, "status after tail");
    send_pkt(3, 81, 4'b0);
    check("R12", status, st(1'b0, 4'b0, 3), "next packet normal");
    rd_byte(pat(81, 0), "R12");

    finish_run();
  end
endmodule